// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address order for a single synchronous DRAM burst. A controller gives it a start column together with the burst length code and the burst order, and pulses a start request. From the next clock on, the sequencer presents one column per cycle. It flags the final beat of a finite burst and raises a one-cycle completion pulse after the burst ends. A burst ends when its programmed length runs out, or when the controller asserts burst-stop.

Finite bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned block that holds the start column. The low bits either count upward and wrap, or are the start column XORed with the beat number. A full-page burst walks the 512-column page upward, wraps from 511 to 0, and runs until it is stopped. A start request made during the completion pulse begins the next burst at once, so bursts can run back to back with no idle beat between them.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `beat_valid_o`, `last_o` and `done_o` are all low.
- R2: A start request made while no burst is running is taken at the clock edge. In the next cycle `beat_valid_o` is high and `col_o` equals the start column. After that, one beat follows per clock with no gaps.
- R3: Length codes 0, 1, 2 and 3 (bit 2 clear) give bursts of exactly 1, 2, 4 and 8 beats.
- R4: With `btype_i` = 0 (sequential), beat i of a finite burst of length L has low log2(L) bits equal to (start low bits + i) mod L. The column bits above them stay equal to those of the start column.
- R5: With `btype_i` = 1 (interleaved), beat i of a finite burst has low log2(L) bits equal to the start low bits XOR i, and the upper bits are unchanged.
- R6: Any length code with bit 2 set selects a full-page burst. Each beat is (start + i) mod 512, whatever the value of `btype_i`, and the burst continues until burst-stop.
- R7: `last_o` is high only on beat L-1 of a finite burst. It is never high during a full-page burst.
- R8: When `stop_i` is high in a cycle with a valid beat, that beat is the final one, and no beat is valid in the next cycle. This holds at every length, and on beat 0 too.
- R9: `done_o` is high for exactly one cycle, the cycle after the final or stopped beat. `beat_valid_o` is low in that cycle.
- R10: A start request made while a burst is running has no effect on the columns of that burst. A burst-stop made while idle has no effect.
- R11: A start request made in the cycle that `done_o` is high is taken. Beat 0 of the new burst appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only when no burst is running |
| start_col_i | input | 9 | First column of the burst |
| blen_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats, bit 2 set gives full page |
| btype_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Burst-stop: the current beat becomes the final one |
| col_o | output | 9 | Column of the current beat |
| beat_valid_o | output | 1 | A beat is presented in this cycle |
| last_o | output | 1 | Current beat is the final beat of a finite burst |
| done_o | output | 1 | One-cycle pulse after a burst ends |

## Verification
A wrong beat index or a wrong latched start column appears on `col_o` in the very next beat. The expected column for every beat is computed independently as base plus offset, so such a fault is caught within one cycle of its cause. A wrong length decode or a bad end condition moves `last_o` and `done_o` by at least one cycle, or leaves a valid beat where none should be. The stop, chaining and start-while-busy tests watch those ports cycle by cycle. A wrap fault in full-page mode appears at the 511-to-0 crossing, which the bench reaches directly.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_XOR = 1'b1
  } order_e;

  // number of beats in a finite burst whose log2 length is lg
  function automatic int unsigned finite_beats(input int unsigned lg);
    return 32'd1 << lg;
  endfunction

  // keep the bits above lg of the start column, and build the low lg bits
  // either by wrapping addition or by XOR with the beat number
  function automatic logic [15:0] merge_low(input logic [15:0] start,
                                            input logic [15:0] beat,
                                            input int unsigned lg,
                                            input logic xor_mode);
    logic [15:0] mask;
    logic [15:0] low;
    mask = (16'd1 << lg) - 16'd1;
    low  = xor_mode ? ((start ^ beat) & mask) : ((start + beat) & mask);
    return (start & ~mask) | low;
  endfunction

endpackage

// File: rtl/burst_seq_addr.sv
module burst_seq_addr
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int LG_MAX = 3,
  localparam int N_LEN = LG_MAX + 1,
  localparam int LG_W  = $clog2(N_LEN)
) (
  input  logic [COL_W-1:0] base_col_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [LG_W-1:0]  lg_i,
  input  logic             page_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] cand [N_LEN];
  logic [COL_W-1:0] page_col;

  // one candidate column for every finite burst length
  for (genvar g = 0; g < N_LEN; g++) begin : g_len
    assign cand[g] = COL_W'(merge_low(16'(base_col_i), 16'(beat_i),
                                      g, order_i == ORDER_XOR));
  end

  // a full page wraps over the whole column range
  assign page_col = base_col_i + beat_i;

  always_comb begin
    if (page_i) col_o = page_col;
    else        col_o = cand[lg_i];
  end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int LG_MAX = 3,
  localparam int LG_W  = $clog2(LG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LG_W-1:0]  lg_i,
  input  logic             page_i,
  input  order_e           order_i,
  output logic             busy_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output logic [LG_W-1:0]  lg_o,
  output logic             page_o,
  output order_e           order_o,
  output logic             last_o,
  output logic             done_o,
  output logic             accept_o,
  output logic             ending_o
);

  logic             busy_q;
  logic             done_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] base_q;
  logic [LG_W-1:0]  lg_q;
  logic             page_q;
  order_e           order_q;
  logic [COL_W-1:0] final_beat;

  assign final_beat = COL_W'(finite_beats(32'(lg_q)) - 1);
  assign accept_o   = start_i & ~busy_q;
  assign last_o     = busy_q & ~page_q & (beat_q == final_beat);
  assign ending_o   = busy_q & (stop_i | last_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      beat_q  <= '0;
      base_q  <= '0;
      lg_q    <= '0;
      page_q  <= 1'b0;
      order_q <= ORDER_SEQ;
    end else begin
      done_q <= ending_o;
      if (busy_q) begin
        if (ending_o) busy_q <= 1'b0;
        else          beat_q <= beat_q + 1'b1;
      end else if (start_i) begin
        busy_q  <= 1'b1;
        beat_q  <= '0;
        base_q  <= start_col_i;
        lg_q    <= lg_i;
        page_q  <= page_i;
        order_q <= order_i;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign beat_o  = beat_q;
  assign base_o  = base_q;
  assign lg_o    = lg_q;
  assign page_o  = page_q;
  assign order_o = order_q;

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int LG_MAX = 3,
  localparam int LG_W  = $clog2(LG_MAX + 1),
  localparam int CODE_W = LG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] blen_i,
  input  logic              btype_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_valid_o,
  output logic              last_o,
  output logic              done_o
);

  logic             busy_w;
  logic [COL_W-1:0] beat_w;
  logic [COL_W-1:0] base_w;
  logic [LG_W-1:0]  lg_w;
  logic             full_w;
  order_e           order_w;
  logic             accept_w;
  logic             ending_w;
  order_e           order_in_w;

  assign order_in_w = btype_i ? ORDER_XOR : ORDER_SEQ;

  burst_seq_ctrl #(.COL_W(COL_W), .LG_MAX(LG_MAX)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .start_col_i(start_col_i),
    .lg_i       (blen_i[LG_W-1:0]),
    .page_i     (blen_i[LG_W]),
    .order_i    (order_in_w),
    .busy_o     (busy_w),
    .beat_o     (beat_w),
    .base_o     (base_w),
    .lg_o       (lg_w),
    .page_o     (full_w),
    .order_o    (order_w),
    .last_o     (last_o),
    .done_o     (done_o),
    .accept_o   (accept_w),
    .ending_o   (ending_w)
  );

  burst_seq_addr #(.COL_W(COL_W), .LG_MAX(LG_MAX)) u_addr (
    .base_col_i(base_w),
    .beat_i    (beat_w),
    .lg_i      (lg_w),
    .page_i    (full_w),
    .order_i   (order_w),
    .col_o     (col_o)
  );

  assign beat_valid_o = busy_w;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W  = 9,
  parameter int LG_MAX = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_valid_o,
  input logic             last_o,
  input logic             done_o,
  input logic             full_w,
  input logic             accept_w,
  input logic             ending_w
);

  // R2: accepted start gives beat 0 at the start column
  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (beat_valid_o && col_o == $past(start_col_i)));

  // R4: upper column bits hold inside a finite burst
  assert_upper_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !full_w && !ending_w) |=>
      (col_o[COL_W-1:LG_MAX] == $past(col_o[COL_W-1:LG_MAX])));

  // R6: full page steps by one modulo the page size
  assert_page_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && full_w && !stop_i) |=>
      (beat_valid_o && col_o == COL_W'($past(col_o) + 1'b1)));

  // R7: no last flag in a full-page burst, and last leads to done
  assert_last_finite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> !full_w);
  assert_last_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> done_o);

  // R8: a stop on a valid beat ends the burst
  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && stop_i) |=> (done_o && !beat_valid_o));

  // R9: no beat in the completion cycle, and the pulse is one cycle long
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !beat_valid_o);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11: start during the completion pulse gives a beat next cycle
  assert_chain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> beat_valid_o);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .LG_MAX(LG_MAX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .beat_valid_o(beat_valid_o),
  .last_o      (last_o),
  .done_o      (done_o),
  .full_w      (full_w),
  .accept_w    (accept_w),
  .ending_w    (ending_w)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NO_STOP    = 1023;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] blen_i = '0;
  logic       btype_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       beat_valid_o;
  logic       last_o;
  logic       done_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq u_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .btype_i(btype_i), .stop_i(stop_i), .col_o(col_o),
    .beat_valid_o(beat_valid_o), .last_o(last_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [8:0] col;
    logic [2:0] code;
    logic       typ;
    logic [9:0] stop_at;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{9'd5,   3'd0, 1'b0, 10'd1023},
    '{9'd13,  3'd1, 1'b0, 10'd1023},
    '{9'd13,  3'd1, 1'b1, 10'd1023},
    '{9'd5,   3'd2, 1'b0, 10'd1023},
    '{9'd5,   3'd2, 1'b1, 10'd1023},
    '{9'd509, 3'd3, 1'b0, 10'd1023},
    '{9'd509, 3'd3, 1'b1, 10'd1023},
    '{9'd42,  3'd3, 1'b1, 10'd3},
    '{9'd510, 3'd7, 1'b0, 10'd5},
    '{9'd300, 3'd5, 1'b1, 10'd2},
    '{9'd7,   3'd2, 1'b0, 10'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected column: aligned base plus an offset inside the block
  function automatic int exp_col(input int sc, input int code, input bit typ, input int i);
    int len, off, base;
    if (code >= 4) return (sc + i) % 512;
    len  = 1 << code;
    off  = sc % len;
    base = sc - off;
    if (typ) return base + (off ^ i);
    return base + ((off + i) % len);
  endfunction

  // entered and left at a falling edge; leaves the bench in the done cycle
  task automatic run_burst(input int sc, input int code, input bit typ, input int stop_at,
                           input string tag);
    int n;
    n = (code >= 4) ? 600 : (1 << code);
    start_i = 1'b1; start_col_i = 9'(sc); blen_i = 3'(code); btype_i = typ;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(beat_valid_o === 1'b1, {"R2 valid ", tag}, int'(beat_valid_o), 1);
      chk(col_o === 9'(exp_col(sc, code, typ, i)),
          (code >= 4) ? {"R6 col ", tag} : (typ ? {"R5 col ", tag} : {"R4 col ", tag}),
          int'(col_o), exp_col(sc, code, typ, i));
      chk(last_o === (code < 4 && i == n - 1), {"R7 last ", tag}, int'(last_o),
          int'(code < 4 && i == n - 1));
      if (i == stop_at) stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      if (i == stop_at) break;
    end
    chk(done_o === 1'b1, {"R9 done ", tag}, int'(done_o), 1);
    chk(beat_valid_o === 1'b0, {"R8 R9 no beat after end ", tag}, int'(beat_valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(beat_valid_o === 1'b0 && last_o === 1'b0 && done_o === 1'b0,
        "R1 reset outputs", int'({beat_valid_o, last_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(beat_valid_o === 1'b0 && done_o === 1'b0, "R1 after reset",
        int'({beat_valid_o, done_o}), 0);

    // table walk: R3 lengths, R4/R5 orders, R6 page wrap, R8 stop
    for (int v = 0; v < NV; v++) begin
      run_burst(int'(VEC[v].col), int'(VEC[v].code), VEC[v].typ,
                int'(VEC[v].stop_at), "R3 table");
      @(negedge clk);
      chk(done_o === 1'b0, "R9 done single cycle", int'(done_o), 0);
    end

    // R11: back-to-back bursts, started in the done cycle
    run_burst(100, 2, 1'b0, NO_STOP, "R11 first");
    run_burst(200, 1, 1'b1, NO_STOP, "R11 chained");
    run_burst(511, 6, 1'b0, 1, "R11 chained page");
    @(negedge clk);

    // R10: start while busy is ignored
    start_i = 1'b1; start_col_i = 9'd16; blen_i = 3'd3; btype_i = 1'b0;
    @(negedge clk);
    start_col_i = 9'd100; blen_i = 3'd0; btype_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk(col_o === 9'(16 + i) && beat_valid_o === 1'b1, "R10 start ignored while busy",
          int'(col_o), 16 + i);
      if (i == 6) start_i = 1'b0;
      @(negedge clk);
      if (i == 6) start_i = 1'b0;
    end
    chk(done_o === 1'b1, "R10 burst ends at length 8", int'(done_o), 1);
    @(negedge clk);

    // R10: stop while idle is ignored
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(done_o === 1'b0 && beat_valid_o === 1'b0, "R10 idle stop ignored",
        int'({done_o, beat_valid_o}), 0);

    // R8: stop on beat 0 of a one-beat burst still ends after one beat
    run_burst(77, 0, 1'b1, 0, "R8 stop len1");
    @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule